// File: doc/BRIEF.md
# Split Instruction/Data Page Translation Unit

This block translates virtual addresses for a 32-bit core that keeps two direct-mapped translation buffers: one for instruction fetches and one for data accesses. Each buffer entry holds two 32-bit words. The match word carries the virtual page number and a valid flag. The translate word carries the physical page number and the access rights. A request brings a virtual address, an access kind (fetch, load or store), the privilege level and a translation-enable flag. One cycle later the unit returns a physical address, the rights that were granted and a fault code.

When translation is enabled, the unit reads both entries at the index given by the address. The instruction and data entries at one index may point at different physical pages. In that case the unit drops the entry that the current access does not use. It grants each right only from an entry that is valid and whose tag matches. If the needed right is missing, it reports either a page fault or a buffer miss. A page fault means a valid entry matched but denied the access. A miss means no such entry existed.

On every reported fault the unit captures the faulting virtual address. It also invalidates the reservation address by setting it to all ones. A dedicated input loads the reservation address at other times. Entry words are loaded through a simple write port. Refill and page-table walking happen elsewhere.

Top module: `tlb_xlate_unit`

## Requirements
- R1: The entry index is virtual address bits [18:13], because pages are 8 KiB and each buffer holds 64 entries. The write port selects the buffer with wr_sel_i[1] (0 instruction, 1 data) and the word with wr_sel_i[0] (0 match word, 1 translate word). The entry is selected by wr_idx_i.
- R2: An entry hits only when bit 0 of its match word is 1 and match word bits [31:13] equal virtual address bits [31:13].
- R3: The rights vector rsp_perm_o has bit 0 = read, bit 1 = write and bit 2 = execute. Execute comes from the instruction translate word: bit 7 in supervisor mode, bit 6 in user mode. Read comes from the data translate word: bit 7 supervisor, bit 6 user. Write also comes from the data translate word: bit 9 supervisor, bit 8 user. Each right is reported only if its own entry hits.
- R4: The physical address is translate word bits [31:13] followed by virtual address bits [12:0].
- R5: req_kind_i encodes the access: 0 = fetch (needs execute), 2 = store (needs write), 1 or 3 = load (needs read). The fault code rsp_exc_o is 0 exactly when the needed right is granted.
- R6: Fault codes are 1 = instruction page fault, 2 = data page fault, 3 = instruction miss and 4 = data miss. On a denied fetch, the code is 1 if the instruction entry hit and 3 otherwise. On a denied load or store, the code is 2 if the data entry hit and 4 otherwise.
- R7: If the two translate words at the indexed position differ in bits [31:13], a fetch ignores the data entry and a load or store ignores the instruction entry. A shared physical page uses both entries.
- R8: With req_mmu_on_i low, the physical address equals the virtual address, rsp_perm_o is 3'b111 and rsp_exc_o is 0, whatever the buffer contents.
- R9: A request that ends with a nonzero fault code loads fault_addr_o with its virtual address and sets lock_addr_o to all ones. Otherwise lock_set_i loads lock_data_i into lock_addr_o, and a fault in the same cycle wins over it. Neither register changes at any other time.
- R10: rsp_valid_o is high for exactly the cycle after a cycle with req_valid_i high, and the response fields belong to that request. A lookup sees the entry contents as they stood before an entry write made in the same cycle.
- R11: The active-low asynchronous reset clears all entry words, the response outputs, fault_addr_o and lock_addr_o. A translated request made right after reset therefore reports a miss.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Translation request strobe |
| req_vaddr_i | input | 32 | Virtual address |
| req_kind_i | input | 2 | Access kind: 0 fetch, 1 load, 2 store, 3 load |
| req_super_i | input | 1 | Supervisor privilege |
| req_mmu_on_i | input | 1 | Translation enabled |
| wr_en_i | input | 1 | Entry word write strobe |
| wr_sel_i | input | 2 | [1] buffer (0 instr, 1 data), [0] word (0 match, 1 translate) |
| wr_idx_i | input | 6 | Entry index to write |
| wr_data_i | input | 32 | Entry word value |
| lock_set_i | input | 1 | Load reservation address |
| lock_data_i | input | 32 | Reservation address to load |
| rsp_valid_o | output | 1 | Response valid, one cycle after request |
| rsp_paddr_o | output | 32 | Physical address |
| rsp_perm_o | output | 3 | Granted rights: [0] read, [1] write, [2] execute |
| rsp_exc_o | output | 3 | Fault code (0 none, 1..4 per R6) |
| fault_addr_o | output | 32 | Last faulting virtual address |
| lock_addr_o | output | 32 | Reservation address |

## Verification
The hardest situation to reach from the ports is the split-page case. It needs an index whose instruction and data translate words name different physical pages, with only one of the two entries valid or matching. Only then does the dropped entry decide between a page fault and a miss. The directed stimulus builds such an index explicitly and then invalidates one side. The random phase draws physical pages and tags from a pool of three values over four indices, so split and shared pages recur often. A second hard case is an entry write in the same cycle as a lookup of that entry, which is driven directly to show that the old contents decide the result.

// File: rtl/xlate_pkg.sv
package xlate_pkg;

  typedef enum logic [1:0] {
    ACC_FETCH = 2'd0,
    ACC_LOAD  = 2'd1,
    ACC_STORE = 2'd2,
    ACC_LOAD2 = 2'd3
  } acc_kind_e;

  typedef enum logic [2:0] {
    EXC_NONE  = 3'd0,
    EXC_IPAGE = 3'd1,
    EXC_DPAGE = 3'd2,
    EXC_IMISS = 3'd3,
    EXC_DMISS = 3'd4
  } xlate_exc_e;

  // rights vector positions
  localparam int unsigned PERM_W  = 3;
  localparam int unsigned PERM_RD = 0;
  localparam int unsigned PERM_WR = 1;
  localparam int unsigned PERM_EX = 2;

  // translate word right bits
  localparam int unsigned TW_USR_RD = 6;
  localparam int unsigned TW_SUP_RD = 7;
  localparam int unsigned TW_USR_WR = 8;
  localparam int unsigned TW_SUP_WR = 9;
  localparam int unsigned TW_USR_EX = 6;
  localparam int unsigned TW_SUP_EX = 7;

  // buffer select
  localparam int unsigned BUF_INSTR = 0;
  localparam int unsigned BUF_DATA  = 1;
  localparam int unsigned NUM_BUF   = 2;

endpackage

// File: rtl/tlb_array.sv
module tlb_array #(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned IDX_W  = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic              wsel_tr_i,
  input  logic [IDX_W-1:0]  widx_i,
  input  logic [ADDR_W-1:0] wdata_i,
  input  logic [IDX_W-1:0]  ridx_i,
  output logic [ADDR_W-1:0] mword_o,
  output logic [ADDR_W-1:0] tword_o
);
  localparam int unsigned DEPTH = 1 << IDX_W;

  logic [ADDR_W-1:0] match_q [DEPTH];
  logic [ADDR_W-1:0] xlat_q  [DEPTH];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) begin
        match_q[i] <= '0;
        xlat_q[i]  <= '0;
      end
    end else if (we_i) begin
      if (wsel_tr_i) xlat_q[widx_i]  <= wdata_i;
      else           match_q[widx_i] <= wdata_i;
    end
  end

  // read before write: same-cycle lookup sees old contents
  assign mword_o = match_q[ridx_i];
  assign tword_o = xlat_q[ridx_i];

endmodule

// File: rtl/xlate_eval.sv
module xlate_eval
  import xlate_pkg::*;
#(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned OFF_W  = 13
) (
  input  logic              [ADDR_W-1:0] vaddr_i,
  input  acc_kind_e                      kind_i,
  input  logic                           super_i,
  input  logic                           mmu_on_i,
  input  logic              [ADDR_W-1:0] imatch_i,
  input  logic              [ADDR_W-1:0] ixlat_i,
  input  logic              [ADDR_W-1:0] dmatch_i,
  input  logic              [ADDR_W-1:0] dxlat_i,
  output logic              [ADDR_W-1:0] paddr_o,
  output logic              [PERM_W-1:0] perm_o,
  output xlate_exc_e                     exc_o
);
  logic [ADDR_W-1:0] im, it, dm, dt;
  logic              is_fetch, is_store, split_pg;
  logic              i_hit, d_hit, r_ex, r_rd, r_wr, need_ok;
  logic [PERM_W-1:0] granted;

  assign is_fetch = (kind_i == ACC_FETCH);
  assign is_store = (kind_i == ACC_STORE);
  assign split_pg = (ixlat_i[ADDR_W-1:OFF_W] != dxlat_i[ADDR_W-1:OFF_W]);

  // drop the entry the access does not use when pages disagree
  always_comb begin
    im = imatch_i;
    it = ixlat_i;
    dm = dmatch_i;
    dt = dxlat_i;
    if (split_pg) begin
      if (is_fetch) begin
        dm = '0;
        dt = '0;
      end else begin
        im = '0;
        it = '0;
      end
    end
  end

  assign i_hit = im[0] && (im[ADDR_W-1:OFF_W] == vaddr_i[ADDR_W-1:OFF_W]);
  assign d_hit = dm[0] && (dm[ADDR_W-1:OFF_W] == vaddr_i[ADDR_W-1:OFF_W]);

  assign r_ex = i_hit && (super_i ? it[TW_SUP_EX] : it[TW_USR_EX]);
  assign r_rd = d_hit && (super_i ? dt[TW_SUP_RD] : dt[TW_USR_RD]);
  assign r_wr = d_hit && (super_i ? dt[TW_SUP_WR] : dt[TW_USR_WR]);

  always_comb begin
    granted          = '0;
    granted[PERM_EX] = r_ex;
    granted[PERM_RD] = r_rd;
    granted[PERM_WR] = r_wr;
  end

  assign need_ok = is_fetch ? r_ex : (is_store ? r_wr : r_rd);

  always_comb begin
    if (!mmu_on_i) begin
      paddr_o = vaddr_i;
      perm_o  = '1;
      exc_o   = EXC_NONE;
    end else begin
      paddr_o = {(it[ADDR_W-1:OFF_W] | dt[ADDR_W-1:OFF_W]), vaddr_i[OFF_W-1:0]};
      perm_o  = granted;
      if (need_ok)       exc_o = EXC_NONE;
      else if (is_fetch) exc_o = i_hit ? EXC_IPAGE : EXC_IMISS;
      else               exc_o = d_hit ? EXC_DPAGE : EXC_DMISS;
    end
  end

endmodule

// File: rtl/fault_track.sv
module fault_track #(
  parameter int unsigned ADDR_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              fault_i,
  input  logic [ADDR_W-1:0] vaddr_i,
  input  logic              lock_set_i,
  input  logic [ADDR_W-1:0] lock_data_i,
  output logic [ADDR_W-1:0] fault_addr_o,
  output logic [ADDR_W-1:0] lock_addr_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fault_addr_o <= '0;
      lock_addr_o  <= '0;
    end else if (fault_i) begin
      fault_addr_o <= vaddr_i;
      lock_addr_o  <= '1;
    end else if (lock_set_i) begin
      lock_addr_o  <= lock_data_i;
    end
  end

endmodule

// File: rtl/tlb_xlate_unit.sv
module tlb_xlate_unit
  import xlate_pkg::*;
#(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned OFF_W  = 13,
  parameter int unsigned IDX_W  = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  input  logic [ADDR_W-1:0] req_vaddr_i,
  input  logic [1:0]        req_kind_i,
  input  logic              req_super_i,
  input  logic              req_mmu_on_i,
  input  logic              wr_en_i,
  input  logic [1:0]        wr_sel_i,
  input  logic [IDX_W-1:0]  wr_idx_i,
  input  logic [ADDR_W-1:0] wr_data_i,
  input  logic              lock_set_i,
  input  logic [ADDR_W-1:0] lock_data_i,
  output logic              rsp_valid_o,
  output logic [ADDR_W-1:0] rsp_paddr_o,
  output logic [2:0]        rsp_perm_o,
  output logic [2:0]        rsp_exc_o,
  output logic [ADDR_W-1:0] fault_addr_o,
  output logic [ADDR_W-1:0] lock_addr_o
);
  localparam int unsigned IDX_LO = OFF_W;
  localparam int unsigned IDX_HI = OFF_W + IDX_W - 1;

  logic [IDX_W-1:0]  ridx;
  logic [ADDR_W-1:0] mword [NUM_BUF];
  logic [ADDR_W-1:0] tword [NUM_BUF];
  logic [ADDR_W-1:0] paddr_d;
  logic [PERM_W-1:0] perm_d;
  xlate_exc_e        exc_d;
  logic              fault_d;

  assign ridx = req_vaddr_i[IDX_HI:IDX_LO];

  for (genvar g = 0; g < NUM_BUF; g++) begin : g_buf
    tlb_array #(
      .ADDR_W (ADDR_W),
      .IDX_W  (IDX_W)
    ) u_arr (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .we_i      (wr_en_i && (wr_sel_i[1] == 1'(g))),
      .wsel_tr_i (wr_sel_i[0]),
      .widx_i    (wr_idx_i),
      .wdata_i   (wr_data_i),
      .ridx_i    (ridx),
      .mword_o   (mword[g]),
      .tword_o   (tword[g])
    );
  end

  xlate_eval #(
    .ADDR_W (ADDR_W),
    .OFF_W  (OFF_W)
  ) u_eval (
    .vaddr_i  (req_vaddr_i),
    .kind_i   (acc_kind_e'(req_kind_i)),
    .super_i  (req_super_i),
    .mmu_on_i (req_mmu_on_i),
    .imatch_i (mword[BUF_INSTR]),
    .ixlat_i  (tword[BUF_INSTR]),
    .dmatch_i (mword[BUF_DATA]),
    .dxlat_i  (tword[BUF_DATA]),
    .paddr_o  (paddr_d),
    .perm_o   (perm_d),
    .exc_o    (exc_d)
  );

  assign fault_d = req_valid_i && (exc_d != EXC_NONE);

  fault_track #(
    .ADDR_W (ADDR_W)
  ) u_fault (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .fault_i      (fault_d),
    .vaddr_i      (req_vaddr_i),
    .lock_set_i   (lock_set_i),
    .lock_data_i  (lock_data_i),
    .fault_addr_o (fault_addr_o),
    .lock_addr_o  (lock_addr_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rsp_valid_o <= 1'b0;
      rsp_paddr_o <= '0;
      rsp_perm_o  <= '0;
      rsp_exc_o   <= '0;
    end else begin
      rsp_valid_o <= req_valid_i;
      if (req_valid_i) begin
        rsp_paddr_o <= paddr_d;
        rsp_perm_o  <= perm_d;
        rsp_exc_o   <= exc_d;
      end
    end
  end

endmodule

// File: rtl/tlb_xlate_chk.sv
module tlb_xlate_chk #(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned OFF_W  = 13
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_valid_i,
  input logic [ADDR_W-1:0] req_vaddr_i,
  input logic [1:0]        req_kind_i,
  input logic              req_mmu_on_i,
  input logic              lock_set_i,
  input logic [ADDR_W-1:0] lock_data_i,
  input logic              rsp_valid_o,
  input logic [ADDR_W-1:0] rsp_paddr_o,
  input logic [2:0]        rsp_perm_o,
  input logic [2:0]        rsp_exc_o,
  input logic [ADDR_W-1:0] fault_addr_o,
  input logic [ADDR_W-1:0] lock_addr_o
);
  logic armed_q;
  logic rsp_fault;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) armed_q <= 1'b0;
    else         armed_q <= 1'b1;
  end

  assign rsp_fault = rsp_valid_o && (rsp_exc_o != 3'd0);

  assert_rsp_follows_req_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i |=> rsp_valid_o);

  assert_no_rsp_without_req_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_valid_i |=> !rsp_valid_o);

  assert_offset_kept_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |-> rsp_paddr_o[OFF_W-1:0] == $past(req_vaddr_i[OFF_W-1:0]));

  assert_bypass_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && !req_mmu_on_i) |=>
      (rsp_paddr_o == $past(req_vaddr_i) && rsp_perm_o == 3'b111 && rsp_exc_o == 3'd0));

  assert_need_vs_code_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |->
      ((($past(req_kind_i) == 2'd0) ? rsp_perm_o[2] :
        ($past(req_kind_i) == 2'd2) ? rsp_perm_o[1] : rsp_perm_o[0]) == (rsp_exc_o == 3'd0)));

  assert_fetch_code_kind_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_valid_o && $past(req_kind_i) == 2'd0) |->
      (rsp_exc_o == 3'd0 || rsp_exc_o == 3'd1 || rsp_exc_o == 3'd3));

  assert_data_code_kind_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_valid_o && $past(req_kind_i) != 2'd0) |->
      (rsp_exc_o == 3'd0 || rsp_exc_o == 3'd2 || rsp_exc_o == 3'd4));

  assert_fault_capture_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_fault |-> (fault_addr_o == $past(req_vaddr_i) && lock_addr_o == '1));

  assert_fault_addr_quiet_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(fault_addr_o) |-> rsp_fault);

  assert_lock_load_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (armed_q && $past(lock_set_i) && !rsp_fault) |-> lock_addr_o == $past(lock_data_i));

endmodule

bind tlb_xlate_unit tlb_xlate_chk #(
  .ADDR_W (ADDR_W),
  .OFF_W  (OFF_W)
) i_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .req_valid_i  (req_valid_i),
  .req_vaddr_i  (req_vaddr_i),
  .req_kind_i   (req_kind_i),
  .req_mmu_on_i (req_mmu_on_i),
  .lock_set_i   (lock_set_i),
  .lock_data_i  (lock_data_i),
  .rsp_valid_o  (rsp_valid_o),
  .rsp_paddr_o  (rsp_paddr_o),
  .rsp_perm_o   (rsp_perm_o),
  .rsp_exc_o    (rsp_exc_o),
  .fault_addr_o (fault_addr_o),
  .lock_addr_o  (lock_addr_o)
);

// File: tb/test_tlb_xlate_unit.sv
module test_tlb_xlate_unit;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req_valid_i = 1'b0;
  logic [31:0] req_vaddr_i = '0;
  logic [1:0]  req_kind_i = '0;
  logic        req_super_i = 1'b0;
  logic        req_mmu_on_i = 1'b0;
  logic        wr_en_i = 1'b0;
  logic [1:0]  wr_sel_i = '0;
  logic [5:0]  wr_idx_i = '0;
  logic [31:0] wr_data_i = '0;
  logic        lock_set_i = 1'b0;
  logic [31:0] lock_data_i = '0;
  logic        rsp_valid_o;
  logic [31:0] rsp_paddr_o;
  logic [2:0]  rsp_perm_o;
  logic [2:0]  rsp_exc_o;
  logic [31:0] fault_addr_o;
  logic [31:0] lock_addr_o;

  int total = 0;
  int bad = 0;
  bit done = 0;

  // reference state
  logic [31:0] m_im [64];
  logic [31:0] m_it [64];
  logic [31:0] m_dm [64];
  logic [31:0] m_dt [64];
  logic [31:0] e_fault, e_lock;

  always #(CLK_PERIOD/2) clk = ~clk;

  tlb_xlate_unit i_tlb_xlate_unit (
    .clk_i(clk), .rst_ni(rst_ni),
    .req_valid_i(req_valid_i), .req_vaddr_i(req_vaddr_i), .req_kind_i(req_kind_i),
    .req_super_i(req_super_i), .req_mmu_on_i(req_mmu_on_i),
    .wr_en_i(wr_en_i), .wr_sel_i(wr_sel_i), .wr_idx_i(wr_idx_i), .wr_data_i(wr_data_i),
    .lock_set_i(lock_set_i), .lock_data_i(lock_data_i),
    .rsp_valid_o(rsp_valid_o), .rsp_paddr_o(rsp_paddr_o), .rsp_perm_o(rsp_perm_o),
    .rsp_exc_o(rsp_exc_o), .fault_addr_o(fault_addr_o), .lock_addr_o(lock_addr_o)
  );

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  function automatic logic [31:0] mw(input logic [31:0] va, input bit v);
    return {va[31:13], 12'h000, v};
  endfunction

  // rights nibble: {sup_wr, usr_wr, sup_rd, usr_rd} (exec uses low two)
  function automatic logic [31:0] tw(input logic [18:0] ppn, input logic [3:0] r);
    return {ppn, 13'h0} | ({28'h0, r} << 6);
  endfunction

  function automatic void ref_lookup(input logic [31:0] va, input logic [1:0] k,
      input logic sup, input logic on,
      output logic [31:0] pa, output logic [2:0] pm, output logic [2:0] ex);
    logic [31:0] im, it, dm, dt;
    int idx;
    bit ih, dh, rx, rr, rw, ok;
    if (!on) begin
      pa = va; pm = 3'b111; ex = 3'd0;
      return;
    end
    idx = int'(va[18:13]);
    im = m_im[idx]; it = m_it[idx]; dm = m_dm[idx]; dt = m_dt[idx];
    if (it[31:13] != dt[31:13]) begin
      if (k == 2'd0) begin dm = 0; dt = 0; end
      else begin im = 0; it = 0; end
    end
    ih = im[0] && (im[31:13] == va[31:13]);
    dh = dm[0] && (dm[31:13] == va[31:13]);
    rx = ih && (sup ? it[7] : it[6]);
    rr = dh && (sup ? dt[7] : dt[6]);
    rw = dh && (sup ? dt[9] : dt[8]);
    pm = {rx, rw, rr};
    pa = {it[31:13] | dt[31:13], va[12:0]};
    ok = (k == 2'd0) ? rx : (k == 2'd2) ? rw : rr;
    if (ok) ex = 3'd0;
    else if (k == 2'd0) ex = ih ? 3'd1 : 3'd3;
    else ex = dh ? 3'd2 : 3'd4;
  endfunction

  task automatic model_clear();
    for (int i = 0; i < 64; i++) begin
      m_im[i] = 0; m_it[i] = 0; m_dm[i] = 0; m_dt[i] = 0;
    end
    e_fault = 0; e_lock = 0;
  endtask

  // one clock: drive at negedge, predict at posedge, compare at next negedge
  task automatic cyc(input logic rv, input logic [31:0] va, input logic [1:0] k,
                     input logic sup, input logic on,
                     input logic we, input logic [1:0] ws, input logic [5:0] wi,
                     input logic [31:0] wd, input logic ls, input logic [31:0] ld,
                     input string tag);
    logic [31:0] pa; logic [2:0] pm, ex;
    req_valid_i = rv; req_vaddr_i = va; req_kind_i = k; req_super_i = sup;
    req_mmu_on_i = on; wr_en_i = we; wr_sel_i = ws; wr_idx_i = wi; wr_data_i = wd;
    lock_set_i = ls; lock_data_i = ld;
    @(posedge clk);
    pa = 0; pm = 0; ex = 0;
    if (rv) ref_lookup(va, k, sup, on, pa, pm, ex);
    if (rv && ex != 0) begin e_fault = va; e_lock = '1; end
    else if (ls) e_lock = ld;
    if (we) begin
      case (ws)
        2'd0: m_im[wi] = wd;
        2'd1: m_it[wi] = wd;
        2'd2: m_dm[wi] = wd;
        default: m_dt[wi] = wd;
      endcase
    end
    @(negedge clk);
    chk(rsp_valid_o === rv, tag, "rsp_valid", 32'(rsp_valid_o), 32'(rv));
    if (rv) begin
      chk(rsp_paddr_o === pa, tag, "paddr", rsp_paddr_o, pa);
      chk(rsp_perm_o === pm, tag, "perm", 32'(rsp_perm_o), 32'(pm));
      chk(rsp_exc_o === ex, tag, "exc", 32'(rsp_exc_o), 32'(ex));
    end
    chk(fault_addr_o === e_fault, tag, "fault_addr", fault_addr_o, e_fault);
    chk(lock_addr_o === e_lock, tag, "lock_addr", lock_addr_o, e_lock);
  endtask

  task automatic wr(input logic [1:0] ws, input logic [5:0] wi, input logic [31:0] wd,
                    input string tag);
    cyc(0, 0, 0, 0, 1, 1, ws, wi, wd, 0, 0, tag);
  endtask

  task automatic rq(input logic [31:0] va, input logic [1:0] k, input logic sup,
                    input string tag);
    cyc(1, va, k, sup, 1, 0, 0, 0, 0, 0, 0, tag);
  endtask

  task automatic do_reset();
    rst_ni = 1'b0;
    req_valid_i = 0; wr_en_i = 0; lock_set_i = 0;
    repeat (2) @(negedge clk);
    model_clear();
    rst_ni = 1'b1;
    chk(rsp_valid_o === 1'b0, "R11", "rsp_valid", 32'(rsp_valid_o), 0);
    chk(rsp_exc_o === 3'd0, "R11", "exc", 32'(rsp_exc_o), 0);
    chk(fault_addr_o === 0, "R11", "fault_addr", fault_addr_o, 0);
    chk(lock_addr_o === 0, "R11", "lock_addr", lock_addr_o, 0);
  endtask

  localparam logic [31:0] VA_A = 32'h4000_2000;  // index 1
  localparam logic [31:0] VA_C = 32'h4000_4000;  // index 2
  localparam logic [31:0] VA_E = 32'h1000_A000;  // index 5
  localparam logic [31:0] VA_T = 32'h0007_E000;  // index 63
  localparam logic [31:0] VA_Z = 32'h8000_0000;  // index 0

  initial begin
    model_clear();
    @(negedge clk);
    do_reset();

    // R11: empty buffers miss after reset
    rq(VA_A + 32'h10, 2'd1, 0, "R11");
    rq(VA_A + 32'h10, 2'd0, 1, "R11");

    // R1 R2 R3 R4: shared page, exec user only, data read both, write sup only
    wr(2'd0, 6'd1, mw(VA_A, 1), "R1");
    wr(2'd1, 6'd1, tw(19'h0ABCD, 4'b0001), "R1");
    wr(2'd2, 6'd1, mw(VA_A, 1), "R1");
    wr(2'd3, 6'd1, tw(19'h0ABCD, 4'b1011), "R1");
    rq(VA_A + 32'h123, 2'd0, 0, "R3");
    rq(VA_A + 32'h123, 2'd0, 1, "R6");
    rq(VA_A + 32'h1FFF, 2'd1, 0, "R4");
    rq(VA_A + 32'h4, 2'd2, 0, "R6");
    rq(VA_A + 32'h4, 2'd2, 1, "R5");
    rq(VA_A + 32'h8, 2'd3, 0, "R5");
    // R2: same index, other tag
    rq(VA_A + 32'h0008_0000, 2'd1, 1, "R2");
    rq(VA_A + 32'h0008_0000, 2'd0, 0, "R2");

    // R7: split pages at index 2
    wr(2'd0, 6'd2, mw(VA_C, 1), "R7");
    wr(2'd1, 6'd2, tw(19'h00111, 4'b1111), "R7");
    wr(2'd2, 6'd2, mw(VA_C, 1), "R7");
    wr(2'd3, 6'd2, tw(19'h00222, 4'b1111), "R7");
    rq(VA_C + 32'h40, 2'd0, 0, "R7");
    rq(VA_C + 32'h40, 2'd2, 0, "R7");
    wr(2'd0, 6'd2, mw(VA_C, 0), "R7");
    rq(VA_C + 32'h40, 2'd0, 1, "R7");
    rq(VA_C + 32'h40, 2'd1, 1, "R7");

    // R1: index boundaries 0 and 63
    wr(2'd2, 6'd63, mw(VA_T, 1), "R1");
    wr(2'd3, 6'd63, tw(19'h7FFFF, 4'b0101), "R1");
    wr(2'd2, 6'd0, mw(VA_Z, 1), "R1");
    wr(2'd3, 6'd0, tw(19'h00001, 4'b0100), "R1");
    rq(VA_T + 32'h55, 2'd1, 0, "R1");
    rq(VA_T + 32'h55, 2'd2, 0, "R1");
    rq(VA_Z + 32'h77, 2'd2, 0, "R1");
    rq(VA_Z + 32'h77, 2'd1, 0, "R3");

    // R8: bypass ignores contents, leaves fault/lock
    cyc(1, 32'hDEAD_BEEF, 2'd2, 0, 0, 0, 0, 0, 0, 0, 0, "R8");
    cyc(1, VA_A + 32'h8, 2'd0, 1, 0, 0, 0, 0, 0, 0, 0, "R8");

    // R9: lock load, untouched by a hit, fault wins in same cycle
    cyc(0, 0, 0, 0, 1, 0, 0, 0, 0, 1, 32'h0000_0100, "R9");
    rq(VA_A + 32'h4, 2'd1, 0, "R9");
    cyc(1, VA_E, 2'd1, 0, 1, 0, 0, 0, 0, 1, 32'h0000_0200, "R9");
    cyc(1, VA_A, 2'd1, 0, 1, 0, 0, 0, 0, 1, 32'h0000_0300, "R9");

    // R10: write and lookup of same entry in one cycle
    cyc(1, VA_E, 2'd1, 0, 1, 1, 2'd2, 6'd5, mw(VA_E, 1), 0, 0, "R10");
    rq(VA_E, 2'd1, 0, "R10");
    cyc(0, 0, 0, 0, 1, 0, 0, 0, 0, 0, 0, "R10");

    // R11: reset wipes entries
    do_reset();
    rq(VA_A + 32'h4, 2'd1, 1, "R11");

    // random phase
    for (int n = 0; n < 4000; n++) begin
      logic [31:0] va, wd;
      logic [5:0] ix;
      logic [1:0] k, ws;
      logic [12:0] tg;
      int sel;
      sel = $urandom_range(0, 3);
      ix = (sel == 3) ? 6'd63 : 6'(sel);
      tg = 13'($urandom_range(0, 2));
      va = {tg, ix, 13'($urandom)};
      k = 2'($urandom);
      ws = 2'($urandom);
      if (ws[0]) wd = tw(19'($urandom_range(0, 2)), 4'($urandom));
      else wd = {13'($urandom_range(0, 2)), ix, 12'h0, ($urandom_range(0, 3) != 0)};
      sel = $urandom_range(0, 3);
      ix = (sel == 3) ? 6'd63 : 6'(sel);
      cyc(($urandom_range(0, 3) != 0), va, k, 1'($urandom),
          ($urandom_range(0, 9) != 0), ($urandom_range(0, 2) == 0), ws, ix, wd,
          ($urandom_range(0, 15) == 0), $urandom, "R5");
    end

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule